// File: doc/BRIEF.md
# Regulator Enable Pattern Sequencer

This block drives the enable line of a voltage regulator that feeds a time-shared analog measurement chain. Once a run request rises, the enable follows a fixed four-segment pattern: on, off, on, off, with unequal segment lengths. The pattern repeats back to back for as long as the request stays high. Dropping the request parks the block in an idle state with the enable low. The next rising edge starts the pattern again from its first cycle.

A 2-bit phase code is reported beside the enable so that surrounding logic or a bench can see which segment is active. One down-counter, reloaded at every segment boundary, times all four segments. The segment lengths are elaboration-time parameters (defaults 72, 240, 172 and 140 cycles, a 624-cycle period).

Top module: `regen_sequencer`

## Requirements
- R1: A start happens on a clock edge where `chain_run` is sampled high after being sampled low at the previous edge. The first edge after reset release counts as having a low previous sample, so a request held high through reset starts the pattern at that edge.
- R2: On the edge that detects a start, the outputs change so that in the following cycle `reg_enable` is 1 and `phase_code` is 0.
- R3: While `chain_run` stays high, phase 0 lasts exactly LEN_HIGH_A cycles, phase 1 exactly LEN_LOW_A, phase 2 exactly LEN_HIGH_B and phase 3 exactly LEN_LOW_B. A length of 1 is legal.
- R4: The phase codes are 0, 1, 2, 3 in that order. `reg_enable` is 1 exactly in codes 0 and 2 while running, and 0 in codes 1 and 3.
- R5: After the last cycle of phase 3, phase 0 follows in the next cycle with no gap, giving a period equal to the sum of the four lengths.
- R6: An edge that samples `chain_run` low moves the block to idle: from the next cycle on, `reg_enable` is 0 and `phase_code` is 0.
- R7: A rise after idle restarts at the first cycle of phase 0, whatever segment and offset the earlier run was interrupted at.
- R8: While `rst_n` is sampled low, the block is forced idle, with `reg_enable` 0, `phase_code` 0 and the segment timer cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| chain_run | input | 1 | Run request; its rising edge starts the pattern, its low level stops it |
| reg_enable | output | 1 | Regulator enable following the four-segment pattern |
| phase_code | output | 2 | Active segment, 0 to 3; 0 when idle |

## Verification
The bench builds the block with segment lengths 5, 7, 1 and 4, a 17-cycle period. This keeps the full period short enough to stop the request at every offset of the period, with both a one-cycle and a two-cycle low gap before each restart. The single-cycle third segment exercises back-to-back reloads of the timer. The short period also allows several uninterrupted wraps, a request held high across reset, and a reset arriving mid-pattern. An arithmetic model of the elapsed cycles since each start predicts every sample.

// File: rtl/vrs_pkg.sv
// Shared types and elaboration helpers for the regulator enable sequencer.
// Assumes: segment lengths are positive integers known at elaboration.
package vrs_pkg;

    // Segment order of the enable pattern; the order is behaviour.
    typedef enum logic [1:0] {
        PH_HIGH_A = 2'd0,
        PH_LOW_A  = 2'd1,
        PH_HIGH_B = 2'd2,
        PH_LOW_B  = 2'd3
    } vrs_phase_e;

    // Largest of four lengths, used to size the shared timer.
    function automatic int unsigned vrs_max4(input int unsigned a, input int unsigned b,
                                             input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Bits needed to hold values 0..v-1, at least one.
    function automatic int unsigned vrs_width(input int unsigned v);
        return (v > 2) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/vrs_rise_detect.sv
// Detects a low-to-high change of a synchronous level between clock edges.
// Assumes: level_i is already synchronous to clk. After reset the previous
// sample reads as low, so a level held high through reset yields a rise.
module vrs_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic level_q;

    // Keep the level sampled at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    // Rise when the current sample is high and the previous one was low.
    assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/vrs_phase_timer.sv
// Segment state machine and shared down-counter of the enable pattern.
// The counter is loaded with length-1 on entry to a segment and the segment
// ends when it reaches zero, so boundaries cost no extra cycle.
// Assumes: every length is at least 1; start_i is only high while run_i is.
module vrs_phase_timer
    import vrs_pkg::*;
#(
    parameter int unsigned LEN_HIGH_A = 72,
    parameter int unsigned LEN_LOW_A  = 240,
    parameter int unsigned LEN_HIGH_B = 172,
    parameter int unsigned LEN_LOW_B  = 140,
    parameter int unsigned CNT_W      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       start_i,
    output logic       active_o,
    output vrs_phase_e phase_o
);

    localparam logic [CNT_W-1:0] RLD_HIGH_A = CNT_W'(LEN_HIGH_A - 1);
    localparam logic [CNT_W-1:0] RLD_LOW_A  = CNT_W'(LEN_LOW_A - 1);
    localparam logic [CNT_W-1:0] RLD_HIGH_B = CNT_W'(LEN_HIGH_B - 1);
    localparam logic [CNT_W-1:0] RLD_LOW_B  = CNT_W'(LEN_LOW_B - 1);

    logic             active_q;
    vrs_phase_e       phase_q;
    vrs_phase_e       phase_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_nx;
    logic             seg_last;

    // Segment that follows the current one, wrapping after the last.
    assign phase_nx = vrs_phase_e'(phase_q + 2'd1);
    assign seg_last = (cnt_q == '0);

    // Reload value for the segment about to be entered.
    always_comb begin
        case (phase_nx)
            PH_HIGH_A: reload_nx = RLD_HIGH_A;
            PH_LOW_A:  reload_nx = RLD_LOW_A;
            PH_HIGH_B: reload_nx = RLD_HIGH_B;
            default:   reload_nx = RLD_LOW_B;
        endcase
    end

    // Idle/start/advance control of segment and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phase_q  <= PH_HIGH_A;
            cnt_q    <= '0;
        end else if (!run_i) begin
            active_q <= 1'b0;
            phase_q  <= PH_HIGH_A;
            cnt_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            phase_q  <= PH_HIGH_A;
            cnt_q    <= RLD_HIGH_A;
        end else if (active_q) begin
            if (seg_last) begin
                phase_q <= phase_nx;
                cnt_q   <= reload_nx;
            end else begin
                cnt_q   <= cnt_q - 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign phase_o  = phase_q;

endmodule

// File: rtl/vrs_enable_drive.sv
// Maps the running segment to the regulator enable level.
// Assumes: HIGH_MASK bit n set means segment n drives the enable high.
module vrs_enable_drive
    import vrs_pkg::*;
#(
    parameter logic [3:0] HIGH_MASK = 4'b0101
) (
    input  logic       active_i,
    input  vrs_phase_e phase_i,
    output logic       enable_o
);

    // Enable is high only while running in a segment marked high.
    assign enable_o = active_i & HIGH_MASK[phase_i];

endmodule

// File: rtl/regen_sequencer.sv
// Top of the regulator enable sequencer: rise detection, segment timer and
// enable decode. Assumes a synchronous run request and positive lengths.
module regen_sequencer
    import vrs_pkg::*;
#(
    parameter int unsigned LEN_HIGH_A = 72,
    parameter int unsigned LEN_LOW_A  = 240,
    parameter int unsigned LEN_HIGH_B = 172,
    parameter int unsigned LEN_LOW_B  = 140
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chain_run,
    output logic       reg_enable,
    output logic [1:0] phase_code
);

    localparam int unsigned LEN_MAX = vrs_max4(LEN_HIGH_A, LEN_LOW_A, LEN_HIGH_B, LEN_LOW_B);
    localparam int unsigned CNT_W   = vrs_width(LEN_MAX);

    // Reject zero-length segments at elaboration.
    generate
        if (LEN_HIGH_A < 1 || LEN_LOW_A < 1 || LEN_HIGH_B < 1 || LEN_LOW_B < 1) begin : g_bad_len
            $error("regen_sequencer: every segment length must be at least 1");
        end
    endgenerate

    logic       start_w;
    logic       active_w;
    vrs_phase_e phase_w;

    vrs_rise_detect u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (chain_run),
        .rise_o  (start_w)
    );

    vrs_phase_timer #(
        .LEN_HIGH_A (LEN_HIGH_A),
        .LEN_LOW_A  (LEN_LOW_A),
        .LEN_HIGH_B (LEN_HIGH_B),
        .LEN_LOW_B  (LEN_LOW_B),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (chain_run),
        .start_i  (start_w),
        .active_o (active_w),
        .phase_o  (phase_w)
    );

    vrs_enable_drive #(
        .HIGH_MASK (4'b0101)
    ) u_drive (
        .active_i (active_w),
        .phase_i  (phase_w),
        .enable_o (reg_enable)
    );

    assign phase_code = phase_w;

endmodule

// File: rtl/regen_sequencer_checker.sv
// Property checker for regen_sequencer, bound to every instance of it.
// Watches only the top-level ports; segment dwell is measured by a local counter.
module regen_sequencer_checker #(
    parameter int unsigned LEN_HIGH_A = 72,
    parameter int unsigned LEN_LOW_A  = 240,
    parameter int unsigned LEN_HIGH_B = 172,
    parameter int unsigned LEN_LOW_B  = 140
) (
    input logic       clk,
    input logic       rst_n,
    input logic       chain_run,
    input logic       reg_enable,
    input logic [1:0] phase_code
);

    logic [1:0]  prev_phase_q;
    logic        prev_en_q;
    int unsigned dwell_q;
    int unsigned dwell_now;
    int unsigned len_now;

    // Length allowed for the segment currently reported.
    always_comb begin
        case (phase_code)
            2'd0:    len_now = LEN_HIGH_A;
            2'd1:    len_now = LEN_LOW_A;
            2'd2:    len_now = LEN_HIGH_B;
            default: len_now = LEN_LOW_B;
        endcase
    end

    // Cycles spent so far with the same phase code and enable level.
    assign dwell_now = (phase_code == prev_phase_q && reg_enable == prev_en_q) ? dwell_q + 1 : 1;

    // Track the run length of the observed output pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_phase_q <= 2'd0;
            prev_en_q    <= 1'b0;
            dwell_q      <= 0;
        end else begin
            prev_phase_q <= phase_code;
            prev_en_q    <= reg_enable;
            dwell_q      <= dwell_now;
        end
    end

    AST_START_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_run) |=> (reg_enable && phase_code == 2'd0)); // R2

    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_run |=> (!reg_enable && phase_code == 2'd0)); // R6

    AST_LEVEL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_enable |-> !phase_code[0]); // R4

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_run && $past(chain_run) && phase_code != $past(phase_code))
        |-> phase_code == 2'($past(phase_code) + 2'd1)); // R5

    AST_DWELL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_enable || phase_code != 2'd0) |-> dwell_now <= len_now); // R3

endmodule

bind regen_sequencer regen_sequencer_checker #(
    .LEN_HIGH_A (LEN_HIGH_A),
    .LEN_LOW_A  (LEN_LOW_A),
    .LEN_HIGH_B (LEN_HIGH_B),
    .LEN_LOW_B  (LEN_LOW_B)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .chain_run  (chain_run),
    .reg_enable (reg_enable),
    .phase_code (phase_code)
);

// File: tb/regen_sequencer_test.sv
`timescale 1ns/1ps
// Bench: small segment lengths, every stop offset swept, arithmetic reference.
module regen_sequencer_test;

    localparam int LA  = 5;
    localparam int LB  = 7;
    localparam int LC  = 1;
    localparam int LD  = 4;
    localparam int PER = LA + LB + LC + LD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chain_run = 1'b0;
    logic       reg_enable;
    logic [1:0] phase_code;

    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string ctx = "R2";

    // Reference state: cycles since last start, -1 when idle.
    int m_since = -1;
    bit m_prev  = 1'b0;
    bit m_rst   = 1'b1;

    regen_sequencer #(
        .LEN_HIGH_A (LA),
        .LEN_LOW_A  (LB),
        .LEN_HIGH_B (LC),
        .LEN_LOW_B  (LD)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_run  (chain_run),
        .reg_enable (reg_enable),
        .phase_code (phase_code)
    );

    always #2.5 clk = ~clk;

    // Reference model advanced at each rising edge from the driven inputs.
    always @(posedge clk) begin
        m_rst = !rst_n;
        if (!rst_n) begin
            m_since = -1;
            m_prev  = 1'b0;
        end else begin
            if (!chain_run)     m_since = -1;
            else if (!m_prev)   m_since = 0;
            else if (m_since >= 0) m_since = m_since + 1;
            m_prev = chain_run;
        end
        chk_on = 1'b1;
    end

    function automatic int exp_phase(input int s);
        int o;
        if (s < 0) return 0;
        o = s % PER;
        if (o < LA) return 0;
        if (o < LA + LB) return 1;
        if (o < LA + LB + LC) return 2;
        return 3;
    endfunction

    function automatic string req_tag(input int s);
        if (m_rst)                       return "R8";
        if (s < 0)                       return "R6";
        if (s == 0)                      return ctx;
        if (s >= PER && (s % PER) == 0)  return "R5";
        return "R3";
    endfunction

    // Compare outputs with the reference away from the rising edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            int  ep;
            bit  ee;
            ep = exp_phase(m_since);
            ee = (m_since >= 0) && (ep == 0 || ep == 2);
            checks++;
            if (phase_code !== 2'(ep) || reg_enable !== ee) begin
                errors++;
                $display("FAIL %s/R4 since=%0d: en=%0b phase=%0d expected en=%0b phase=%0d",
                         req_tag(m_since), m_since, reg_enable, phase_code, ee, ep);
            end
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Stimulus sequence.
    initial begin
        // R8: reset with request low.
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(2);

        // R2, R3, R5: uninterrupted run over several periods.
        ctx = "R2";
        chain_run = 1'b1;
        wait_cycles(3 * PER + 2);
        chain_run = 1'b0;
        wait_cycles(3);

        // R6, R7: stop at every offset, then restart after 1 or 2 low cycles.
        ctx = "R7";
        for (int d = 0; d <= PER; d++) begin
            for (int g = 1; g <= 2; g++) begin
                chain_run = 1'b1;
                wait_cycles(d + 1);
                chain_run = 1'b0;
                wait_cycles(g);
            end
        end
        wait_cycles(2);

        // R1: request held high through reset starts at the first edge after.
        ctx = "R1";
        chain_run = 1'b1;
        rst_n = 1'b0;
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(PER + 3);
        // R8 then R1: reset mid-pattern with request still high.
        rst_n = 1'b0;
        wait_cycles(2);
        rst_n = 1'b1;
        wait_cycles(PER + 2);
        chain_run = 1'b0;
        wait_cycles(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R3 watchdog: stimulus not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule